// File: doc/BRIEF.md
# Service-Flag Status and Interrupt Unit

This unit is the status and interrupt core of a FIFO-based serial peripheral. It does not hold the FIFOs or the shifter. It receives their fill levels, block-ready levels, per-word strobes and error event strobes. From these it keeps a status word with live FIFO level bits and sticky service and done flags. It combines the flags with a service mask and with enabled error flags to drive one active-high, level-sensitive interrupt line.

Software reads and writes eight word registers through a simple single-cycle register port. Sticky flags are acknowledged by writing ones to their positions. Two programmable word limits, one for each direction, raise the done flags when the shifter side has moved that many words. When data moves by DMA, per-direction mask bits silence the service-flag interrupts, and the done and error sources still fire.

Top module: `svc_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, every stored bit (sticky flags, mask, error flags, error enables, limits) reads zero and `irq` is low.
- R2: Status bits 4 (output FIFO not empty), 5 (input FIFO not empty), 6 (output FIFO full) and 7 (input FIFO full) follow their inputs in the same cycle. Writes do not affect them.
- R3: Status bit 8 (output service) sets on a rising edge of `out_blk_room`, and bit 9 (input service) sets on a rising edge of `in_blk_rdy`. Bits 12 and 13 are live copies of `out_blk_room` and `in_blk_rdy`.
- R4: Writing to the status register at address 0 clears each of bits 8 to 11 whose write-data bit is 1. A 0 in the write data leaves that flag unchanged.
- R5: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set. This applies to status flags and to error flags.
- R6: `irq` is a level. It stays high for as long as an unmasked service flag, a done flag, or an enabled error flag is set, and it falls once these are cleared.
- R7: The mask register at address 1 holds bit 8 (masks output service) and bit 9 (masks input service). These bits suppress only the service flags' share of `irq`. The done flags and the errors are not masked.
- R8: The input limit is at address 6 and the output limit at address 7. The words counted are `in_word` and `out_word` strobes. When the count reaches a nonzero limit, status bit 11 (input done, together with bit 9) or bit 10 (output done) sets. The count then holds and sets nothing more until the limit is rewritten, which restarts it from zero. A limit of 0 never sets a done flag.
- R9: Core error flags at address 2 are sticky and write-1-to-clear. Bit 2 is input over-run, bit 3 output under-run, bit 4 input under-run and bit 5 output over-run, set by `core_err_ev[0..3]`. Link error flags at address 4 work the same way: bit 0 is clock under-run and bit 1 clock over-run, set by `link_err_ev[0..1]`.
- R10: An error flag drives `irq` only while the matching bit is set in its enable register: address 3 for core errors and address 5 for link errors.
- R11: The mask, the enables and the limits read back at their own addresses with the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| out_fifo_ne | input | 1 | Output FIFO not empty |
| in_fifo_ne | input | 1 | Input FIFO not empty |
| out_fifo_full | input | 1 | Output FIFO full |
| in_fifo_full | input | 1 | Input FIFO full |
| in_blk_rdy | input | 1 | Input FIFO holds at least one block |
| out_blk_room | input | 1 | Output FIFO has room for one block |
| in_word | input | 1 | One word entered the input FIFO |
| out_word | input | 1 | One word left the output FIFO |
| core_err_ev | input | 4 | Core error event strobes |
| link_err_ev | input | 2 | Serial clock error event strobes |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the unit with a 6-bit word counter and a 32-bit data path. The small counter puts the largest legal limit, 63 words, within a short run. This lets the bench check the done flag one word before the limit and on the limit itself, and check that the count holds once it has reached the limit. The 32-bit data width places every status, mask and error bit in a single word, so the bench can check that reads of an unused position return zero.

// File: rtl/svc_irq_pkg.sv
// Shared register addresses and bit positions for the service-flag unit.
package svc_irq_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_STATUS  = 3'd0;
    localparam logic [REG_AW-1:0] A_MASK    = 3'd1;
    localparam logic [REG_AW-1:0] A_CERR    = 3'd2;
    localparam logic [REG_AW-1:0] A_CERR_EN = 3'd3;
    localparam logic [REG_AW-1:0] A_LERR    = 3'd4;
    localparam logic [REG_AW-1:0] A_LERR_EN = 3'd5;
    localparam logic [REG_AW-1:0] A_IN_LIM  = 3'd6;
    localparam logic [REG_AW-1:0] A_OUT_LIM = 3'd7;

    // Status word layout, decoded by software.
    localparam int B_OUT_NE   = 4;
    localparam int B_IN_NE    = 5;
    localparam int B_OUT_FULL = 6;
    localparam int B_IN_FULL  = 7;
    localparam int B_OUT_SVC  = 8;
    localparam int B_IN_SVC   = 9;
    localparam int B_OUT_DONE = 10;
    localparam int B_IN_DONE  = 11;
    localparam int B_OUT_BLK  = 12;
    localparam int B_IN_BLK   = 13;

    localparam int CERR_LSB = 2;
    localparam int CERR_N   = 4;
    localparam int LERR_N   = 2;

    localparam int DIR_N   = 2;
    localparam int DIR_OUT = 0;
    localparam int DIR_IN  = 1;
endpackage

// File: rtl/svc_sticky_bits.sv
// Bank of N sticky flags. A flag sets on its set strobe and clears on its
// clear strobe. Set has priority over clear in the same cycle.
// Assumes set and clear are synchronous single-cycle strobes.
module svc_sticky_bits #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One flag: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)         q_o[i] <= 1'b0;
            else if (set_i[i])  q_o[i] <= 1'b1;
            else if (clr_i[i])  q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/svc_err_bank.sv
// Error flag register plus its enable register. The flags are sticky and
// write-1-to-clear, and an event wins over a clear. active_o reports any
// flag whose enable is set. Assumes wr_flag_i and wr_en_i are one-cycle strobes.
module svc_err_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic         wr_flag_i,
    input  logic         wr_en_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] en_o,
    output logic         active_o
);
    logic [N-1:0] clr;

    // Clear request: the ones in the write data while the flag register is addressed.
    always_comb clr = wr_flag_i ? wdata_i : '0;

    svc_sticky_bits #(.N(N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_i),
        .clr_i (clr),
        .q_o   (flag_o)
    );

    // Enable register, plain write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= '0;
        else if (wr_en_i) en_o <= wdata_i;
    end

    // Any enabled error.
    always_comb active_o = |(flag_o & en_o);
endmodule

// File: rtl/svc_word_counter.sv
// Programmable word limit and word counter for one direction. reach_o pulses
// on the word that makes the count equal a nonzero limit. The count then holds
// until the limit is rewritten, which also restarts it from zero.
// Assumes word_i is at most one word per cycle.
module svc_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             word_i,
    output logic [CNT_W-1:0] lim_o,
    output logic             reach_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_lim;

    // Counter holds once it equals the limit.
    always_comb at_lim = (cnt_q == lim_o);

    // Pulse on the final word, unless a limit rewrite happens in the same cycle.
    always_comb reach_o = word_i && !lim_wr_i && (lim_o != '0) && (cnt_q == lim_o - ONE);

    // Limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)        lim_o <= '0;
        else if (lim_wr_i) lim_o <= lim_i;
    end

    // Word count: restart on a limit write, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (lim_wr_i)          cnt_q <= '0;
        else if (word_i && !at_lim) cnt_q <= cnt_q + ONE;
    end
endmodule

// File: rtl/svc_irq_unit.sv
// Status register and level interrupt for a FIFO-based serial peripheral.
// It combines live FIFO levels, sticky service and done flags (write 1 to
// clear), a service mask and two enabled error banks into one active-high irq.
// Assumes DATA_W >= 14 and DATA_W >= CNT_W, and that all inputs are
// synchronous to clk.
module svc_irq_unit
    import svc_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              out_fifo_ne,
    input  logic              in_fifo_ne,
    input  logic              out_fifo_full,
    input  logic              in_fifo_full,
    input  logic              in_blk_rdy,
    input  logic              out_blk_room,
    input  logic              in_word,
    input  logic              out_word,
    input  logic [CERR_N-1:0] core_err_ev,
    input  logic [LERR_N-1:0] link_err_ev,
    output logic              irq
);
    localparam int OP_N = B_IN_DONE - B_OUT_SVC + 1;
    localparam int SVC_N = B_IN_SVC - B_OUT_SVC + 1;

    logic              wr_status, wr_mask, wr_cerr, wr_cerr_en, wr_lerr, wr_lerr_en;
    logic [DIR_N-1:0]  lim_wr, word_ev, blk_lvl, blk_q, blk_rise, reach;
    logic [CNT_W-1:0]  lim_v [DIR_N];
    logic [OP_N-1:0]   op_set, op_clr, op_q;
    logic [SVC_N-1:0]  mask_q;
    logic [CERR_N-1:0] cerr_q, cerr_en_q;
    logic [LERR_N-1:0] lerr_q, lerr_en_q;
    logic              cerr_act, lerr_act;
    logic              unused_wbits;

    // Write decode per register.
    always_comb begin
        wr_status  = reg_wr && (reg_addr == A_STATUS);
        wr_mask    = reg_wr && (reg_addr == A_MASK);
        wr_cerr    = reg_wr && (reg_addr == A_CERR);
        wr_cerr_en = reg_wr && (reg_addr == A_CERR_EN);
        wr_lerr    = reg_wr && (reg_addr == A_LERR);
        wr_lerr_en = reg_wr && (reg_addr == A_LERR_EN);
        lim_wr[DIR_IN]  = reg_wr && (reg_addr == A_IN_LIM);
        lim_wr[DIR_OUT] = reg_wr && (reg_addr == A_OUT_LIM);
    end

    // Per-direction input vectors.
    always_comb begin
        blk_lvl[DIR_IN]  = in_blk_rdy;
        blk_lvl[DIR_OUT] = out_blk_room;
        word_ev[DIR_IN]  = in_word;
        word_ev[DIR_OUT] = out_word;
    end

    // Previous block-ready levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= blk_lvl;
    end

    // Rising edge of each block-ready level.
    always_comb blk_rise = blk_lvl & ~blk_q;

    for (genvar d = 0; d < DIR_N; d++) begin : g_dir
        svc_word_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .lim_wr_i (lim_wr[d]),
            .lim_i    (reg_wdata[CNT_W-1:0]),
            .word_i   (word_ev[d]),
            .lim_o    (lim_v[d]),
            .reach_o  (reach[d])
        );
    end

    // Set events for the sticky status flags (index 0 is status bit 8).
    always_comb begin
        op_set = '0;
        op_set[B_OUT_SVC - B_OUT_SVC]  = blk_rise[DIR_OUT];
        op_set[B_IN_SVC - B_OUT_SVC]   = blk_rise[DIR_IN] | reach[DIR_IN];
        op_set[B_OUT_DONE - B_OUT_SVC] = reach[DIR_OUT];
        op_set[B_IN_DONE - B_OUT_SVC]  = reach[DIR_IN];
    end

    // Write-1-to-clear requests for the sticky status flags.
    always_comb op_clr = wr_status ? reg_wdata[B_IN_DONE:B_OUT_SVC] : '0;

    svc_sticky_bits #(.N(OP_N)) u_op (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (op_set),
        .clr_i (op_clr),
        .q_o   (op_q)
    );

    // Service mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata[B_IN_SVC:B_OUT_SVC];
    end

    svc_err_bank #(.N(CERR_N)) u_cerr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (core_err_ev),
        .wr_flag_i (wr_cerr),
        .wr_en_i   (wr_cerr_en),
        .wdata_i   (reg_wdata[CERR_LSB +: CERR_N]),
        .flag_o    (cerr_q),
        .en_o      (cerr_en_q),
        .active_o  (cerr_act)
    );

    svc_err_bank #(.N(LERR_N)) u_lerr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (link_err_ev),
        .wr_flag_i (wr_lerr),
        .wr_en_i   (wr_lerr_en),
        .wdata_i   (reg_wdata[LERR_N-1:0]),
        .flag_o    (lerr_q),
        .en_o      (lerr_en_q),
        .active_o  (lerr_act)
    );

    // Level interrupt from all sources.
    always_comb irq = (|(op_q[SVC_N-1:0] & ~mask_q)) | (|op_q[OP_N-1:SVC_N]) | cerr_act | lerr_act;

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS: begin
                reg_rdata[B_OUT_NE]   = out_fifo_ne;
                reg_rdata[B_IN_NE]    = in_fifo_ne;
                reg_rdata[B_OUT_FULL] = out_fifo_full;
                reg_rdata[B_IN_FULL]  = in_fifo_full;
                reg_rdata[B_IN_DONE:B_OUT_SVC] = op_q;
                reg_rdata[B_OUT_BLK]  = out_blk_room;
                reg_rdata[B_IN_BLK]   = in_blk_rdy;
            end
            A_MASK:    reg_rdata[B_IN_SVC:B_OUT_SVC]   = mask_q;
            A_CERR:    reg_rdata[CERR_LSB +: CERR_N]   = cerr_q;
            A_CERR_EN: reg_rdata[CERR_LSB +: CERR_N]   = cerr_en_q;
            A_LERR:    reg_rdata[LERR_N-1:0]           = lerr_q;
            A_LERR_EN: reg_rdata[LERR_N-1:0]           = lerr_en_q;
            A_IN_LIM:  reg_rdata[CNT_W-1:0]            = lim_v[DIR_IN];
            A_OUT_LIM: reg_rdata[CNT_W-1:0]            = lim_v[DIR_OUT];
            default:   reg_rdata = '0;
        endcase
    end

    // Write-data bits outside every field.
    always_comb unused_wbits = ^reg_wdata;
endmodule

// File: rtl/svc_irq_unit_chk.sv
// Property checker for svc_irq_unit. It is bound to every instance of the
// top module and observes ports and internal flag state.
module svc_irq_unit_chk
    import svc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [1:0]        wsvc,
    input logic [3:0]        rd_lvl,
    input logic [3:0]        lvl_in,
    input logic              in_blk_rdy,
    input logic              out_blk_room,
    input logic [3:0]        op_q,
    input logic [1:0]        mask_q,
    input logic [CERR_N-1:0] cerr_q,
    input logic [CERR_N-1:0] cerr_en_q,
    input logic [LERR_N-1:0] lerr_q,
    input logic [LERR_N-1:0] lerr_en_q,
    input logic              irq
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq);

    p_levels_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STATUS) |-> (rd_lvl == lvl_in));

    p_out_svc_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_blk_room && !$past(out_blk_room)) |=> op_q[0]);

    p_w1c_out_svc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STATUS && wsvc[0] && !out_blk_room) |=> !op_q[0]);

    p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk_rdy && !$past(in_blk_rdy) && reg_wr && reg_addr == A_STATUS && wsvc[1]) |=> op_q[1]);

    p_done_raises_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q[3:2] != 2'b00) |-> irq);

    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q[3:2] == 2'b00 && (op_q[1:0] & ~mask_q) == 2'b00 &&
         (cerr_q & cerr_en_q) == '0 && (lerr_q & lerr_en_q) == '0) |-> !irq);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cerr_q != '0 && !(reg_wr && reg_addr == A_CERR)) |=> ((cerr_q & $past(cerr_q)) == $past(cerr_q)));

    p_enabled_err_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lerr_q & lerr_en_q) != '0) |-> irq);
endmodule

bind svc_irq_unit svc_irq_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .wsvc         (reg_wdata[9:8]),
    .rd_lvl       (reg_rdata[7:4]),
    .lvl_in       ({in_fifo_full, out_fifo_full, in_fifo_ne, out_fifo_ne}),
    .in_blk_rdy   (in_blk_rdy),
    .out_blk_room (out_blk_room),
    .op_q         (op_q),
    .mask_q       (mask_q),
    .cerr_q       (cerr_q),
    .cerr_en_q    (cerr_en_q),
    .lerr_q       (lerr_q),
    .lerr_en_q    (lerr_en_q),
    .irq          (irq)
);

// File: tb/svc_irq_unit_test.sv
module svc_irq_unit_test;
    localparam int DW = 32;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          out_fifo_ne = 1'b0, in_fifo_ne = 1'b0;
    logic          out_fifo_full = 1'b0, in_fifo_full = 1'b0;
    logic          in_blk_rdy = 1'b0, out_blk_room = 1'b0;
    logic          in_word = 1'b0, out_word = 1'b0;
    logic [3:0]    core_err_ev = '0;
    logic [1:0]    link_err_ev = '0;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Scoreboard queues: kind 0 = read data, kind 1 = irq.
    bit          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    svc_irq_unit #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_fifo_ne(out_fifo_ne), .in_fifo_ne(in_fifo_ne),
        .out_fifo_full(out_fifo_full), .in_fifo_full(in_fifo_full),
        .in_blk_rdy(in_blk_rdy), .out_blk_room(out_blk_room),
        .in_word(in_word), .out_word(out_word),
        .core_err_ev(core_err_ev), .link_err_ev(link_err_ev), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Driver: queue the expected read value and irq, then let the monitor sample.
    task automatic look(input logic [2:0] a, input logic [31:0] exp_rd, input logic exp_irq, input string tag);
        reg_addr = a;
        kind_q.push_back(1'b0); exp_q.push_back(exp_rd);          tag_q.push_back(tag);
        kind_q.push_back(1'b1); exp_q.push_back({31'b0, exp_irq}); tag_q.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_in(input int n);
        for (int i = 0; i < n; i++) begin in_word = 1'b1; tick(); in_word = 1'b0; end
    endtask

    task automatic pulse_out(input int n);
        for (int i = 0; i < n; i++) begin out_word = 1'b1; tick(); out_word = 1'b0; end
    endtask

    // Monitor: pop and compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (kind_q.size() > 0) begin
                bit k;
                logic [31:0] e, act;
                string t;
                k = kind_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
                act = k ? {31'b0, irq} : reg_rdata;
                n_chk++;
                if (act !== e) begin
                    n_fail++;
                    $display("FAIL %s (%s): actual 0x%0h expected 0x%0h", t, k ? "irq" : "rdata", act, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        look(3'd0, 32'h0, 1'b0, "R1 status");
        look(3'd1, 32'h0, 1'b0, "R1 mask");
        look(3'd3, 32'h0, 1'b0, "R1 core enable");
        look(3'd6, 32'h0, 1'b0, "R1 in limit");

        // R2: live level bits, writes ignored
        out_fifo_ne = 1'b1; in_fifo_full = 1'b1;
        look(3'd0, 32'h90, 1'b0, "R2 levels live");
        wr(3'd0, 32'hF0);
        look(3'd0, 32'h90, 1'b0, "R2 write ignored");
        out_fifo_ne = 1'b0; in_fifo_full = 1'b0; in_fifo_ne = 1'b1; out_fifo_full = 1'b1;
        look(3'd0, 32'h60, 1'b0, "R2 other levels");
        in_fifo_ne = 1'b0; out_fifo_full = 1'b0;

        // R3 / R6: output service on rising room
        out_blk_room = 1'b1; tick();
        look(3'd0, 32'h1100, 1'b1, "R3 out service set, R6 irq");
        // R4: write 1 clears, level held high does not re-set
        wr(3'd0, 32'h100);
        look(3'd0, 32'h1000, 1'b0, "R4 w1c out service");
        out_blk_room = 1'b0; tick();
        out_blk_room = 1'b1; tick();
        wr(3'd0, 32'h0);
        look(3'd0, 32'h1100, 1'b1, "R4 write zero no effect");
        // R7: mask output service
        wr(3'd1, 32'h100);
        look(3'd1, 32'h100, 1'b0, "R7 mask suppresses, R11 readback");
        wr(3'd0, 32'h100);
        out_blk_room = 1'b0;
        wr(3'd1, 32'h0);
        look(3'd0, 32'h0, 1'b0, "R4 cleared");

        // R5: set wins over clear
        in_blk_rdy = 1'b1;
        wr(3'd0, 32'h200);
        look(3'd0, 32'h2200, 1'b1, "R5 set beats clear, R3 in service");
        wr(3'd0, 32'h200);
        look(3'd0, 32'h2000, 1'b0, "R4 w1c in service");
        in_blk_rdy = 1'b0; tick();

        // R8: input limit
        wr(3'd6, 32'd3);
        look(3'd6, 32'd3, 1'b0, "R11 in limit readback");
        pulse_in(2);
        look(3'd0, 32'h0, 1'b0, "R8 before limit");
        pulse_in(1);
        look(3'd0, 32'hA00, 1'b1, "R8 in done and service");
        wr(3'd1, 32'h300);
        look(3'd0, 32'hA00, 1'b1, "R7 done not masked");
        wr(3'd0, 32'hA00);
        look(3'd0, 32'h0, 1'b0, "R8 cleared");
        pulse_in(2);
        look(3'd0, 32'h0, 1'b0, "R8 count holds");
        wr(3'd6, 32'd3);
        pulse_in(3);
        look(3'd0, 32'hA00, 1'b1, "R8 restart on rewrite");
        wr(3'd0, 32'hA00);
        wr(3'd1, 32'h0);
        // R8: output limit at its maximum
        wr(3'd7, 32'd63);
        pulse_out(62);
        look(3'd0, 32'h0, 1'b0, "R8 out one short");
        pulse_out(1);
        look(3'd0, 32'h400, 1'b1, "R8 out done");
        wr(3'd0, 32'h400);
        look(3'd7, 32'd63, 1'b0, "R11 out limit readback");
        // R8: zero limit never fires
        wr(3'd6, 32'd0);
        pulse_in(5);
        look(3'd0, 32'h0, 1'b0, "R8 zero limit");

        // R9 / R10: core errors
        core_err_ev = 4'b0001; tick(); core_err_ev = '0;
        look(3'd2, 32'h4, 1'b0, "R9 core flag, R10 disabled");
        wr(3'd3, 32'h4);
        look(3'd3, 32'h4, 1'b1, "R10 enabled drives irq");
        wr(3'd2, 32'h0);
        look(3'd2, 32'h4, 1'b1, "R9 zero write keeps");
        wr(3'd2, 32'h4);
        look(3'd2, 32'h0, 1'b0, "R9 w1c");
        core_err_ev = 4'b1000;
        wr(3'd2, 32'h20);
        core_err_ev = '0;
        look(3'd2, 32'h20, 1'b0, "R5 error set beats clear");
        wr(3'd2, 32'h20);
        look(3'd2, 32'h0, 1'b0, "R9 cleared");

        // R9 / R10: link errors
        link_err_ev = 2'b10; tick(); link_err_ev = '0;
        look(3'd4, 32'h2, 1'b0, "R9 link flag");
        wr(3'd5, 32'h1);
        look(3'd4, 32'h2, 1'b0, "R10 other enable");
        wr(3'd5, 32'h2);
        look(3'd5, 32'h2, 1'b1, "R10 link enabled");
        wr(3'd4, 32'h2);
        look(3'd4, 32'h0, 1'b0, "R6 irq falls after clear");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule